// File: doc/BRIEF.md
# Gated 13-bit split timer

This block is a 13-bit up-counter whose value is held in two byte-wide registers. The high byte holds the eight upper bits and the low byte holds the five lower bits. Software loads a start value through a small register port and then sets a run bit. Once a gate-mode bit is set, an active-low external pin also has to be asserted for the count to advance. That pin is synchronised into the clock domain first. Software can then measure how long the pin stays low.

A clock-select bit picks the count source. The counter advances either on every clock or only on cycles where an external prescaler strobe is high. When the count wraps from its maximum back to zero, a sticky overflow flag is set. The interrupt request is the overflow flag combined with an interrupt-enable bit. Software clears the flag by writing 0 to it.

Top module: `split13_timer`

## Requirements
- R1: The count is read back in two bytes: address 1 returns count bits 12..5, and address 0 returns count bits 4..0 in data bits 4..0.
- R2: Data bits 7..5 of a read at address 0 always return 0.
- R3: A count of 0x1FFF wraps to 0x0000 on an increment. That increment sets the overflow flag, which is bit 4 of the control register at address 2. `irq_req` is high exactly when the overflow flag and the interrupt-enable bit (control bit 3) are both 1.
- R4: With the run bit (control bit 0) at 0, the count never changes except through byte writes.
- R5: With run at 1 and gate mode (control bit 1) at 0, the count advances whatever the level of `gate_pin_n`.
- R6: With run at 1 and gate mode at 1, the count advances only while `gate_pin_n` is low. The pin reaches the gate logic through a two-flop synchroniser.
- R7: Setting the run bit leaves the count unchanged.
- R8: With clock select (control bit 2) at 0, the count advances on every enabled clock. With clock select at 1, it advances only on enabled cycles where `presc_en` is high.
- R9: A byte write takes priority over an increment in the same cycle. A write to address 0 changes only count bits 4..0, and a write to address 1 changes only count bits 12..5.
- R10: Writing 0 to control bit 4 clears the overflow flag, and writing 1 to it has no effect. If a wrap happens in the same cycle as the clearing write, the flag ends up set.
- R11: A synchronous active-low reset clears the count, the overflow flag and every control bit. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_en | input | 1 | Pre-scaled count strobe, one cycle wide |
| gate_pin_n | input | 1 | Asynchronous active-low gate pin |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Interrupt request (flag AND enable) |

## Verification
The hardest case to reach from the ports is a wrap landing in the same cycle as a software write that clears the flag. The stimulus runs the counter, loads 0x1FFE with a low-byte write, lets it rise to 0x1FFF, and places the clearing control write on the very edge where the wrap happens.

The gate pin is also hard to check, because its effect arrives two cycles late. A behavioural model in the bench carries its own two-stage pin delay and is compared with the read port and the interrupt request on every clock. Directed windows then check that the count holds while the pin is high and that it moves again once the pin goes low.

// File: rtl/s13_pkg.sv
`timescale 1ns/1ps
// Package: shared register addresses and control-field layout for the split timer.
// Assumes an 8-bit register port and a 2-bit address.
package s13_pkg;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 5;

    // Register addresses; the decode in s13_regs depends on these values.
    typedef enum logic [ADDR_W-1:0] {
        A_LOW  = 2'd0,
        A_HIGH = 2'd1,
        A_CTRL = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    // Control register, packed so that run is bit 0 and flag is bit 4.
    typedef struct packed {
        logic flag;
        logic ie;
        logic csel;
        logic gate;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/s13_sync.sv
`timescale 1ns/1ps
// Module: multi-flop synchroniser for the asynchronous gate pin.
// Assumes STAGES >= 2; the flops reset to RST_VAL (the pin's inactive level).
module s13_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/s13_tick_gen.sv
`timescale 1ns/1ps
// Module: decides whether the counter advances this cycle.
// Assumes pin_sync_n is already synchronous; the pin is active low.
module s13_tick_gen (
    input  logic run,
    input  logic gate,
    input  logic pin_sync_n,
    input  logic csel,
    input  logic presc_en,
    output logic tick
);
    logic gate_open;
    logic src_en;

    // Combine the run bit, the gate condition and the count source.
    always_comb begin
        gate_open = !gate || !pin_sync_n;
        src_en    = csel ? presc_en : 1'b1;
        tick      = run && gate_open && src_en;
    end
endmodule

// File: rtl/s13_counter.sv
`timescale 1ns/1ps
// Module: split up-counter with per-field loads.
// A load of either field blocks the increment in that cycle.
// wrap pulses on an increment from all ones.
module s13_counter #(
    parameter int LO_W = 5,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 ld_lo,
    input  logic                 ld_hi,
    input  logic [LO_W-1:0]      lo_val,
    input  logic [HI_W-1:0]      hi_val,
    output logic [LO_W+HI_W-1:0] cnt,
    output logic                 wrap
);
    localparam int CNT_W = LO_W + HI_W;

    logic any_ld;
    assign any_ld = ld_lo || ld_hi;

    // Load fields with priority over counting, otherwise increment on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (any_ld) begin
            if (ld_lo) cnt[LO_W-1:0]     <= lo_val;
            if (ld_hi) cnt[CNT_W-1:LO_W] <= hi_val;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the increment that rolls the count over.
    assign wrap = tick && !any_ld && (cnt == {CNT_W{1'b1}});

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !any_ld && cnt != {CNT_W{1'b1}}) |=> (cnt == $past(cnt) + 1'b1)); // R5
    AST_LOW_LOAD_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && !ld_hi) |=> (cnt[CNT_W-1:LO_W] == $past(cnt[CNT_W-1:LO_W]))); // R9
endmodule

// File: rtl/s13_regs.sv
`timescale 1ns/1ps
// Module: register port for the split timer.
// It holds the control register and the sticky flag, decodes the byte loads,
// muxes read data and forms the interrupt request.
// Assumes DATA_W equals HI_W and is at least LO_W and CTRL_W.
module s13_regs import s13_pkg::*; #(
    parameter int LO_W   = 5,
    parameter int HI_W   = 8,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [LO_W+HI_W-1:0] cnt,
    input  logic                 wrap,
    output ctrl_t                ctrl,
    output logic                 ld_lo,
    output logic                 ld_hi,
    output logic [LO_W-1:0]      lo_val,
    output logic [HI_W-1:0]      hi_val,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_req
);
    localparam int CNT_W = LO_W + HI_W;

    logic ctrl_wr;
    logic flag_clr;

    // Decode the write strobes for each register.
    always_comb begin
        ld_lo    = bus_wr && (bus_addr == A_LOW);
        ld_hi    = bus_wr && (bus_addr == A_HIGH);
        ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
        flag_clr = ctrl_wr && !bus_wdata[4];
        lo_val   = bus_wdata[LO_W-1:0];
        hi_val   = bus_wdata[HI_W-1:0];
    end

    // Update the control bits from software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.run  <= 1'b0;
            ctrl.gate <= 1'b0;
            ctrl.csel <= 1'b0;
            ctrl.ie   <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl.run  <= bus_wdata[0];
            ctrl.gate <= bus_wdata[1];
            ctrl.csel <= bus_wdata[2];
            ctrl.ie   <= bus_wdata[3];
        end
    end

    // Sticky overflow flag: a wrap wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl.flag <= 1'b0;
        else if (wrap)     ctrl.flag <= 1'b1;
        else if (flag_clr) ctrl.flag <= 1'b0;
    end

    // Select read data; unused low-byte bits return zero.
    always_comb begin
        case (bus_addr)
            A_LOW:   bus_rdata = {{(DATA_W-LO_W){1'b0}}, cnt[LO_W-1:0]};
            A_HIGH:  bus_rdata = cnt[CNT_W-1:LO_W];
            A_CTRL:  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
            default: bus_rdata = '0;
        endcase
    end

    // Interrupt request follows the flag when enabled.
    assign irq_req = ctrl.flag && ctrl.ie;

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ctrl.flag); // R10
    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !wrap) |=> !ctrl.flag); // R10
    AST_LOW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_LOW) |-> (bus_rdata[DATA_W-1:LO_W] == '0)); // R2
endmodule

// File: rtl/split13_timer.sv
`timescale 1ns/1ps
// Module: gated 13-bit split timer (top).
// Chain: pin synchroniser, then tick generator, then split counter,
// with the register port around it. Assumes DATA_W == HI_W.
module split13_timer import s13_pkg::*; #(
    parameter int LO_W        = 5,
    parameter int HI_W        = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              presc_en,
    input  logic              gate_pin_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req
);
    localparam int CNT_W = LO_W + HI_W;

    ctrl_t            ctrl;
    logic             pin_sync_n;
    logic             tick;
    logic             wrap;
    logic             ld_lo;
    logic             ld_hi;
    logic [LO_W-1:0]  lo_val;
    logic [HI_W-1:0]  hi_val;
    logic [CNT_W-1:0] cnt;

    s13_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(gate_pin_n), .dout(pin_sync_n)
    );

    s13_tick_gen u_tick (
        .run(ctrl.run), .gate(ctrl.gate), .pin_sync_n(pin_sync_n),
        .csel(ctrl.csel), .presc_en(presc_en), .tick(tick)
    );

    s13_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .lo_val(lo_val), .hi_val(hi_val), .cnt(cnt), .wrap(wrap)
    );

    s13_regs #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .cnt(cnt), .wrap(wrap), .ctrl(ctrl),
        .ld_lo(ld_lo), .ld_hi(ld_hi), .lo_val(lo_val), .hi_val(hi_val),
        .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !ld_lo && !ld_hi) |=> $stable(cnt)); // R4
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && ctrl.gate && pin_sync_n && !ld_lo && !ld_hi) |=> $stable(cnt)); // R6
endmodule

// File: tb/sim_split13_timer.sv
`timescale 1ns/1ps
module sim_split13_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_en = 1'b0;
    logic       pin_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    split13_timer u0 (
        .clk(clk), .rst_n(rst_n), .presc_en(presc_en), .gate_pin_n(pin_n),
        .bus_addr(addr), .bus_wr(wr_en), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_req(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model state.
    int m_cnt = 0;
    bit m_run = 0, m_gate = 0, m_csel = 0, m_ie = 0, m_flag = 0;
    bit m_s1 = 1, m_s2 = 1;

    function automatic int m_read(input int a);
        case (a)
            0: return m_cnt & 31;
            1: return m_cnt >> 5;
            2: return (int'(m_flag) << 4) | (int'(m_ie) << 3) | (int'(m_csel) << 2)
                      | (int'(m_gate) << 1) | int'(m_run);
            default: return 0;
        endcase
    endfunction

    // Step the model on every edge, then compare shortly after the edge.
    always @(posedge clk) begin
        bit tk, ovf;
        cyc++;
        tk = m_run && (!m_gate || !m_s2) && (!m_csel || presc_en);
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_gate = 0; m_csel = 0; m_ie = 0; m_flag = 0;
            m_s1 = 1; m_s2 = 1;
        end else begin
            ovf = 0;
            if (wr_en && addr < 2) begin
                if (addr == 0) m_cnt = (m_cnt & ~31) | (int'(wdata) & 31);
                else           m_cnt = (m_cnt & 31) | (int'(wdata) << 5);
            end else if (tk) begin
                if (m_cnt == 8191) begin m_cnt = 0; ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (wr_en && addr == 2) begin
                m_run = wdata[0]; m_gate = wdata[1]; m_csel = wdata[2]; m_ie = wdata[3];
            end
            if (ovf) m_flag = 1;
            else if (wr_en && addr == 2 && !wdata[4]) m_flag = 0;
            m_s2 = m_s1;
            m_s1 = pin_n;
        end
        #1;
        chk("R1 per-cycle read", int'(rdata), m_read(int'(addr)));
        chk("R3 per-cycle irq", int'(irq), int'(m_flag && m_ie));
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 2'(a); wdata = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_now(input int a, input string tag, input int exp);
        addr = 2'(a);
        #0.1;
        chk(tag, int'(rdata), exp);
    endtask

    task automatic get_cnt(output int v);
        addr = 2'd0; #0.1; v = int'(rdata);
        addr = 2'd1; #0.1; v = v | (int'(rdata) << 5);
    endtask

    initial begin
        int v1, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // r11_ reset state
        rd_now(0, "R11 reset low", 0);
        rd_now(1, "R11 reset high", 0);
        rd_now(2, "R11 reset ctrl", 0);
        chk("R11 reset irq", int'(irq), 0);
        rd_now(3, "R11 unused addr", 0);

        // Low byte keeps only five bits; the high byte holds eight.
        wr(0, 8'hFF);
        rd_now(0, "R2 low upper bits zero", 8'h1F);
        wr(1, 8'hAB);
        rd_now(1, "R1 high byte", 8'hAB);

        // Stopped timer holds its value.
        repeat (8) @(negedge clk);
        rd_now(0, "R4 stopped low", 8'h1F);
        rd_now(1, "R4 stopped high", 8'hAB);

        // Load 0x1FF8, start it, and let it wrap.
        wr(1, 8'hFF);
        wr(0, 8'h18);
        wr(2, 8'h09);
        rd_now(0, "R7 run keeps count", 8'h18);
        repeat (8) @(negedge clk);
        rd_now(0, "R3 wrapped low", 0);
        rd_now(1, "R3 wrapped high", 0);
        rd_now(2, "R3 flag set", 8'h19);
        chk("R3 irq raised", int'(irq), 1);

        // Flag clear, then a write of 1 must not set it.
        wr(2, 8'h09);
        rd_now(2, "R10 flag cleared", 8'h09);
        chk("R10 irq dropped", int'(irq), 0);
        wr(2, 8'h19);
        rd_now(2, "R10 write one ignored", 8'h09);

        // Gate mode: pin high stops the count, pin low resumes it.
        pin_n = 1'b1;
        wr(2, 8'h0B);
        repeat (3) @(negedge clk);
        get_cnt(v1);
        repeat (5) @(negedge clk);
        get_cnt(v2);
        chk("R6 gated hold", v2, v1);
        pin_n = 1'b0;
        repeat (4) @(negedge clk);
        get_cnt(v2);
        chk("R6 gate open counts", int'(v2 != v1), 1);

        // Gate mode off: the pin level does not matter.
        pin_n = 1'b1;
        wr(2, 8'h09);
        @(negedge clk);
        get_cnt(v1);
        repeat (5) @(negedge clk);
        get_cnt(v2);
        chk("R5 counts with pin high", v2, (v1 + 5) % 8192);

        // Prescaled source: three strobes give three counts.
        wr(2, 8'h0D);
        presc_en = 1'b0;
        @(negedge clk);
        get_cnt(v1);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            presc_en = (i % 3 == 0);
        end
        @(negedge clk);
        presc_en = 1'b0;
        get_cnt(v2);
        chk("R8 prescaled count", v2, (v1 + 3) % 8192);

        // A write wins over the increment in the same cycle.
        wr(2, 8'h09);
        wr(0, 8'hEA);
        rd_now(0, "R9 low write wins", 8'h0A);
        wr(1, 8'h5C);
        rd_now(1, "R9 high write wins", 8'h5C);

        // A wrap in the same cycle as a clearing write leaves the flag set.
        wr(1, 8'hFF);
        wr(0, 8'h1E);
        wr(2, 8'h09);
        rd_now(2, "R10 wrap beats clear", 8'h19);
        rd_now(0, "R3 wrap low zero", 0);
        chk("R10 irq after race", int'(irq), 1);

        // Reset in the middle of a run.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_now(0, "R11 rerst low", 0);
        rd_now(1, "R11 rerst high", 0);
        rd_now(2, "R11 rerst ctrl", 0);
        chk("R11 rerst irq", int'(irq), 0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule